// File: doc/BRIEF.md
# Reference Clock Loss Monitor

This block times a slow, asynchronous reference clock against a fast system clock. From that timing it decides whether a downstream frequency loop may be treated as locked. It brings the reference into the system domain and finds its rising edges. It counts system cycles between edges to get the reference period, and it sorts each new interval into one of four cases: a match, a tolerated gap, a period change, or (when edges stop) a loss.

The monitor can lose the reference in three ways.
- **Silent stop:** the reference stops and the lock flag holds for a long timeout before it falls.
- **Period change:** a glitch or a step in period drops lock on the edge that reveals it.
- **Gap beyond the skip window:** with skip mode on and the reference slow enough, an interval close to a whole number of periods is read as missing pulses. Lock is kept in that case, as long as the gap stays inside a bounded window; a longer gap drops lock.

After any unlock, a new period must be measured and a relock delay must pass before lock returns. An output-mode input sets what the clock enable does while unlocked: it either keeps the clock running or holds it low.

Top module: `refclk_loss_mon`

## Requirements
- R1: `period_o` holds the accepted reference period, in system cycles from one synchronized rising edge to the next. It reads 0 after reset and after a loss. A new interval within `TOL_CYC` of the stored value replaces it. A tolerated gap leaves it unchanged. A period change loads the new interval.
- R2: If no reference edge arrives for `TIMEOUT_CYC` cycles after the last one, `lock_o` falls and `period_o` returns to 0. Before that, `lock_o` stays high.
- R3: An interval that differs from the stored period by more than `TOL_CYC` is a period change. It drops `lock_o` on the cycle that registers the edge, with no wait for the timeout. A difference of exactly `TOL_CYC` is still a match.
- R4: With `skip_en_i` low, a run of missing reference pulses is a period change and drops lock.
- R5: Lock is kept through a gap when all of these hold. `skip_en_i` is high. The stored period is at least `SKIP_MIN_PER` cycles. The interval is at most `SKIP_WIN_CYC` cycles. The interval lies within `TOL_CYC` of a whole multiple (two or more) of the stored period.
- R6: `skip_en_i` has no effect while the stored period is below `SKIP_MIN_PER`. A gap then counts as a period change.
- R7: An interval longer than `SKIP_WIN_CYC` is a period change even with skip mode on.
- R8: Lock rises only after a period has been measured, which takes two edges. After the edge that loads a new period (first measurement or change), `RELOCK_CYC` cycles must pass before lock rises. A single edge after a loss never starts the delay.
- R9: `clk_en_o` is 1 while locked. While unlocked it is 0 when `unl_low_i` is 1, and 1 when `unl_low_i` is 0.
- R10: Asynchronous reset clears lock and the stored period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Asynchronous reference clock |
| skip_en_i | input | 1 | Enables riding through missing reference pulses |
| unl_low_i | input | 1 | 1: hold clock enable low while unlocked; 0: keep it high |
| lock_o | output | 1 | Lock flag |
| clk_en_o | output | 1 | Gated output clock enable |
| period_o | output | CNT_W | Accepted reference period in system cycles |

## Verification
The embedded assertions check these properties on every cycle:
- a change or loss event is followed by an unlocked state;
- lock only rises out of an armed relock delay;
- a locked monitor always holds a nonzero period;
- a tolerated gap leaves the stored period untouched;
- a gap is only tolerated when skip mode is on and the period is slow enough;
- edge pulses last a single cycle.

Only the bench scenarios can show the interval arithmetic and the window limits:
- the tolerance boundary;
- gap intervals accepted or rejected by the skip window and the slowness limit;
- the actual timeout length;
- the relock delay counted from the second edge.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_PRIME,   // first edge, no interval yet
    EV_NEW,     // first interval stored
    EV_MATCH,
    EV_SKIP,
    EV_CHANGE,
    EV_LOST
  } ref_ev_e;
endpackage

// File: rtl/refmon_edge.sv
module refmon_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic edge_o
);
  logic [STAGES:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[STAGES-1:0], ref_i};
  end

  assign edge_o = s_q[STAGES-1] & ~s_q[STAGES];

  a_r1_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/refmon_meter.sv
module refmon_meter
  import refmon_pkg::*;
#(
  parameter int CNT_W        = 24,
  parameter int TIMEOUT_CYC  = 1 << 23,
  parameter int TOL_CYC      = 4,
  parameter int SKIP_WIN_CYC = 1_000_000,
  parameter int SKIP_MIN_PER = 625
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             skip_en_i,
  output ref_ev_e          ev_o,
  output logic [CNT_W-1:0] per_o
);
  localparam logic [CNT_W-1:0] TMO  = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] TOL  = CNT_W'(TOL_CYC);
  localparam logic [CNT_W-1:0] WIN  = CNT_W'(SKIP_WIN_CYC);
  localparam logic [CNT_W-1:0] MINP = CNT_W'(SKIP_MIN_PER);

  logic [CNT_W-1:0] cnt_q, ph_q, per_q;
  logic             seen_q, valid_q;
  logic [CNT_W-1:0] intv, diff, rem;
  logic             near, mult, skip_ok, lost;

  always_comb begin
    intv    = cnt_q + 1'b1;
    diff    = (intv > per_q) ? intv - per_q : per_q - intv;
    rem     = ph_q + 1'b1;   // interval mod period, 1..period
    near    = diff <= TOL;
    mult    = (intv > per_q) &&
              ((rem <= TOL) || ({1'b0, rem} + {1'b0, TOL} >= {1'b0, per_q}));
    skip_ok = skip_en_i && (per_q >= MINP) && (intv <= WIN);
    lost    = seen_q && (cnt_q >= TMO);
    ev_o    = EV_NONE;
    if (edge_i) begin
      if (!seen_q)              ev_o = EV_PRIME;
      else if (!valid_q)        ev_o = EV_NEW;
      else if (near)            ev_o = EV_MATCH;
      else if (skip_ok && mult) ev_o = EV_SKIP;
      else                      ev_o = EV_CHANGE;
    end else if (lost) begin
      ev_o = EV_LOST;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ph_q    <= '0;
      per_q   <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (edge_i) begin
        cnt_q <= '0;
        ph_q  <= '0;
      end else begin
        if (cnt_q < TMO) cnt_q <= cnt_q + 1'b1;
        ph_q <= (rem >= per_q) ? '0 : rem;
      end
      case (ev_o)
        EV_PRIME: seen_q <= 1'b1;
        EV_NEW, EV_MATCH, EV_CHANGE: begin
          per_q   <= intv;
          valid_q <= 1'b1;
        end
        EV_LOST: begin
          per_q   <= '0;
          valid_q <= 1'b0;
          seen_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign per_o = per_q;

  a_r5_skip_needs_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o == EV_SKIP) |-> (skip_en_i && per_q >= MINP));
  a_r1_skip_keeps_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o == EV_SKIP) |=> $stable(per_q));
  a_r7_skip_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o == EV_SKIP) |-> (cnt_q < WIN));
endmodule

// File: rtl/refmon_lock.sv
module refmon_lock
  import refmon_pkg::*;
#(
  parameter int RELOCK_CYC = 4096
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ref_ev_e ev_i,
  output logic    lock_o
);
  localparam int               RC_W    = $clog2(RELOCK_CYC + 1);
  localparam logic [RC_W-1:0]  RC_LAST = RC_W'(RELOCK_CYC - 1);

  logic            lock_q, armed_q;
  logic [RC_W-1:0] rc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      armed_q <= 1'b0;
      rc_q    <= '0;
    end else begin
      case (ev_i)
        EV_NEW, EV_CHANGE: begin
          lock_q  <= 1'b0;
          armed_q <= 1'b1;
          rc_q    <= '0;
        end
        EV_LOST: begin
          lock_q  <= 1'b0;
          armed_q <= 1'b0;
          rc_q    <= '0;
        end
        default: begin
          if (armed_q) begin
            if (rc_q == RC_LAST) begin
              lock_q  <= 1'b1;
              armed_q <= 1'b0;
            end else begin
              rc_q <= rc_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign lock_o = lock_q;

  a_r3_change_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_CHANGE) |=> !lock_q);
  a_r2_lost_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_LOST) |=> !lock_q);
  a_r8_rise_after_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(armed_q));
endmodule

// File: rtl/refclk_loss_mon.sv
module refclk_loss_mon
  import refmon_pkg::*;
#(
  parameter int CNT_W        = 24,
  parameter int SYNC_STAGES  = 2,
  parameter int TIMEOUT_CYC  = 1 << 23,
  parameter int RELOCK_CYC   = 4096,
  parameter int TOL_CYC      = 4,
  parameter int SKIP_WIN_CYC = 1_000_000,
  parameter int SKIP_MIN_PER = 625
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             skip_en_i,
  input  logic             unl_low_i,
  output logic             lock_o,
  output logic             clk_en_o,
  output logic [CNT_W-1:0] period_o
);
  logic    ref_edge;
  ref_ev_e ev;

  refmon_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_clk_i),
    .edge_o (ref_edge)
  );

  refmon_meter #(
    .CNT_W        (CNT_W),
    .TIMEOUT_CYC  (TIMEOUT_CYC),
    .TOL_CYC      (TOL_CYC),
    .SKIP_WIN_CYC (SKIP_WIN_CYC),
    .SKIP_MIN_PER (SKIP_MIN_PER)
  ) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (ref_edge),
    .skip_en_i (skip_en_i),
    .ev_o      (ev),
    .per_o     (period_o)
  );

  refmon_lock #(.RELOCK_CYC(RELOCK_CYC)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .lock_o (lock_o)
  );

  assign clk_en_o = lock_o | ~unl_low_i;

  a_r1_lock_has_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (period_o != '0));
  a_r9_gate_on_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> clk_en_o);
endmodule

// File: tb/refclk_loss_mon_tb.sv
module refclk_loss_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int TIMEOUT    = 2000;
  localparam int RELOCK     = 64;
  localparam int TOL        = 2;
  localparam int SKIP_WIN   = 600;
  localparam int SKIP_MIN   = 40;

  typedef struct packed {
    int unsigned per;
    int unsigned gap;
    int unsigned n;
    logic        skip;
    logic        lock;
    int unsigned exp_per;
  } row_t;

  localparam int NROWS = 14;
  localparam row_t ROWS [NROWS] = '{
    '{50, 0, 8, 1'b0, 1'b1, 50},   // R8 R1 first lock
    '{51, 0, 4, 1'b0, 1'b1, 51},   // R3 within tolerance
    '{54, 0, 1, 1'b0, 1'b0, 54},   // R3 change by TOL+1
    '{54, 0, 4, 1'b0, 1'b1, 54},   // R8 relock
    '{60, 0, 4, 1'b0, 1'b1, 60},
    '{60, 2, 1, 1'b1, 1'b1, 60},   // R5 gap tolerated
    '{60, 2, 1, 1'b0, 1'b0, 180},  // R4 gap without skip
    '{60, 0, 4, 1'b0, 1'b1, 60},
    '{30, 0, 5, 1'b0, 1'b1, 30},
    '{30, 2, 1, 1'b1, 1'b0, 90},   // R6 too fast for skip
    '{60, 0, 4, 1'b1, 1'b1, 60},
    '{60, 12, 1, 1'b1, 1'b0, 780}, // R7 beyond window
    '{60, 0, 4, 1'b0, 1'b1, 60},
    '{62, 0, 1, 1'b1, 1'b1, 62}    // R3 diff equal to TOL
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic skip_en = 1'b0;
  logic unl_low = 1'b1;
  logic lock, clk_en;
  logic [CNT_W-1:0] period;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refclk_loss_mon #(
    .CNT_W        (CNT_W),
    .SYNC_STAGES  (2),
    .TIMEOUT_CYC  (TIMEOUT),
    .RELOCK_CYC   (RELOCK),
    .TOL_CYC      (TOL),
    .SKIP_WIN_CYC (SKIP_WIN),
    .SKIP_MIN_PER (SKIP_MIN)
  ) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ref_clk_i (ref_clk),
    .skip_en_i (skip_en),
    .unl_low_i (unl_low),
    .lock_o    (lock),
    .clk_en_o  (clk_en),
    .period_o  (period)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // rising edges of consecutive pulses are exactly p cycles apart
  task automatic pulse(input int p);
    ref_clk = 1'b0;
    idle(p - 6);
    ref_clk = 1'b1;
    idle(2);
    ref_clk = 1'b0;
    idle(4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(2);
    chk("R10 reset lock", int'(lock), 0);
    chk("R10 reset period", int'(period), 0);
    chk("R9 unlocked gated low", int'(clk_en), 0);
    unl_low = 1'b0;
    idle(1);
    chk("R9 unlocked pass mode", int'(clk_en), 1);
    unl_low = 1'b1;
    do_reset();

    // R8 relock delay counted from the second edge
    pulse(50);
    idle(30);
    chk("R8 one edge no period", int'(period), 0);
    pulse(50);
    chk("R1 first period", int'(period), 80);
    idle(50);
    chk("R8 still in relock delay", int'(lock), 0);
    idle(20);
    chk("R8 locked after delay", int'(lock), 1);
    chk("R9 locked enable", int'(clk_en), 1);

    // R2 silent stop
    idle(1900);
    chk("R2 held before timeout", int'(lock), 1);
    idle(60);
    chk("R2 unlocked after timeout", int'(lock), 0);
    chk("R2 period cleared", int'(period), 0);
    chk("R9 gated after loss", int'(clk_en), 0);

    // R8 single edge after loss does not start relock
    pulse(50);
    idle(150);
    chk("R8 single edge after loss lock", int'(lock), 0);
    chk("R8 single edge after loss period", int'(period), 0);

    do_reset();
    for (int i = 0; i < NROWS; i++) begin
      skip_en = ROWS[i].skip;
      ref_clk = 1'b0;
      idle(int'(ROWS[i].gap * ROWS[i].per));
      for (int k = 0; k < int'(ROWS[i].n); k++) pulse(int'(ROWS[i].per));
      chk($sformatf("R3/R4/R5/R6/R7 row %0d lock", i), int'(lock), int'(ROWS[i].lock));
      chk($sformatf("R1 row %0d period", i), int'(period), int'(ROWS[i].exp_per));
      chk($sformatf("R9 row %0d enable", i), int'(clk_en), int'(ROWS[i].lock));
    end

    // R10 reset while locked
    rst_n = 1'b0;
    idle(1);
    chk("R10 reset clears lock", int'(lock), 0);
    chk("R10 reset clears period", int'(period), 0);
    rst_n = 1'b1;
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule